// File: doc/BRIEF.md
# Fine-Adjust 8-bit Reload Timer

This block is an 8-bit down-counting timer fed by a power-of-two prescaler on the peripheral clock. Software writes a reload value, picks a division code and a one-shot or repeat mode, and starts or stops counting through a run bit. Each time the counter passes zero it reloads, pulses an underflow output for one clock and sets an interrupt flag. The flag drives the interrupt output only when its separate enable bit is set, and software clears it by writing 1.

A fine-adjust field tunes the average period in sixteenths of a count clock. A 4-bit underflow-cycle index steps once per underflow. The period that ends at a given index is lengthened by one count clock when the bit-reversed index is below the fine value. This spreads the lengthened periods evenly over each group of 16. Software can also force a reload of the counter at any time by writing 1 to a load-now bit.

All access goes through a small 16-bit register bus. The bus has a 3-bit word address, a write strobe and a read strobe. Read data is combinational and is zero while the read strobe is low.

Top module: `fine_reload_timer`

## Requirements
- R1: After reset, every register reads 0, except the counter, which reads 0x00FF. `irq_o` and `uf_o` are low.
- R2: Register map, by word address:
  - 0: control. Bit 0 is run. Bit 1 is load-now (write-only, reads 0). Bit 2 is one-shot. Bits 7:4 are fine.
  - 1: division code, bits 3:0.
  - 2: reload value, bits 7:0.
  - 3: counter, bits 7:0, read-only.
  - 4: interrupt. Bit 0 is the flag. Bit 1 is the enable.

  Unused bits and addresses read 0. Writes to them, and to the counter, are ignored.
- R3: With division code n (0 to 14) and run set, a count enable occurs on every 2^n-th clock. The first enable comes 2^n clocks after the write that sets run. Code 15 gives no enable.
- R4: Each count enable decrements a nonzero counter. At zero, unless a lengthening is due, the count enable reloads the counter from the reload register. In that case `uf_o` is high for the following clock cycle.
- R5: When the bit-reversed underflow-cycle index is less than fine, the counter stays at zero for one extra count enable before it underflows. The index starts at 0 after reset and steps modulo 16 per underflow. With reload 0 and code 0, 16 consecutive underflows therefore span 16 + fine clocks.
- R6: In one-shot mode, an underflow clears the run bit. In repeat mode, run stays set.
- R7: The run bit reads back as written. While run is clear, the counter holds its value.
- R8: Writing control with bit 1 set loads the reload value into the counter on that clock. This overrides a count enable on the same clock and drops a pending lengthening. Writing bit 1 as 0 leaves the counter unchanged.
- R9: An underflow sets the flag. Writing 1 to the flag clears it, and a same-clock underflow wins over the clear. Writing 0 to the flag has no effect. `irq_o` is high exactly when both the flag and the enable are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| wr | input | 1 | Write strobe, one clock per write |
| rd | input | 1 | Read strobe; read data is valid while it is high |
| rdata | output | 16 | Read data |
| irq_o | output | 1 | Interrupt request |
| uf_o | output | 1 | One-cycle underflow pulse |

## Verification
The hardest case to reach is a full 16-underflow fine cycle. The lengthened periods sit at scattered indices, and the index is never visible at the ports. The stimulus uses reload 0 and division code 0, so that every underflow follows one or two clocks after the previous one. It then times 16 consecutive underflow pulses for fine values 0, 5 and 15. The measured spans must be exactly 16 + fine, whatever index the sequence starts from. A reference model that steps on every clock covers the individual lengthening positions.

// File: rtl/ft_pkg.sv
package ft_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV    = 3'd1;
  localparam logic [ADDR_W-1:0] A_RELOAD = 3'd2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_IRQ    = 3'd4;

  localparam int B_RUN     = 0;
  localparam int B_LOAD    = 1;
  localparam int B_ONESHOT = 2;
  localparam int B_FINE_LO = 4;
  localparam int B_FLAG    = 0;
  localparam int B_IEN     = 1;
endpackage

// File: rtl/ft_prescaler.sv
module ft_prescaler #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int PRE_W = (1 << DIV_W) - 2;
  localparam logic [DIV_W-1:0] DIV_RSVD = '1;

  logic [PRE_W-1:0] pre_q, pre_d, mask;

  generate
    for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign mask[i] = (div > DIV_W'(i));
    end
  endgenerate

  assign tick = run && (div != DIV_RSVD) && ((pre_q & mask) == mask);

  always_comb begin
    if (!run) pre_d = '0;
    else      pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/ft_fine_seq.sv
module ft_fine_seq #(
  parameter int FINE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              advance,
  input  logic [FINE_W-1:0] fine,
  output logic              stretch
);
  logic [FINE_W-1:0] idx_q, idx_d, rev;

  generate
    for (genvar i = 0; i < FINE_W; i++) begin : g_rev
      assign rev[i] = idx_q[FINE_W-1-i];
    end
  endgenerate

  assign stretch = (rev < fine);

  always_comb begin
    idx_d = idx_q;
    if (advance) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end
endmodule

// File: rtl/fine_reload_timer.sv
module fine_reload_timer #(
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 4,
  parameter int FINE_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  input  logic        wr,
  input  logic        rd,
  output logic [15:0] rdata,
  output logic        irq_o,
  output logic        uf_o
);
  import ft_pkg::*;

  logic              run_q, run_d, oneshot_q, oneshot_d;
  logic [FINE_W-1:0] fine_q, fine_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [CNT_W-1:0]  reload_q, reload_d, cnt_q, cnt_d;
  logic              delay_q, delay_d, flag_q, flag_d, ien_q, ien_d;
  logic              uf_q, uf_evt, tick, stretch;
  logic              wr_ctrl, wr_div, wr_reload, wr_irq, load_req;

  assign wr_ctrl   = wr && (addr == A_CTRL);
  assign wr_div    = wr && (addr == A_DIV);
  assign wr_reload = wr && (addr == A_RELOAD);
  assign wr_irq    = wr && (addr == A_IRQ);
  assign load_req  = wr_ctrl && wdata[B_LOAD];

  ft_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run_q), .div(div_q), .tick(tick)
  );

  ft_fine_seq #(.FINE_W(FINE_W)) u_fine (
    .clk(clk), .rst_n(rst_n), .advance(uf_evt), .fine(fine_q), .stretch(stretch)
  );

  // counter, lengthening and underflow
  always_comb begin
    uf_evt  = 1'b0;
    cnt_d   = cnt_q;
    delay_d = delay_q;
    if (load_req) begin
      cnt_d   = reload_q;
      delay_d = 1'b0;
    end else if (tick) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else if (stretch && !delay_q) begin
        delay_d = 1'b1;
      end else begin
        uf_evt  = 1'b1;
        cnt_d   = reload_q;
        delay_d = 1'b0;
      end
    end
  end

  // software-visible register next state
  always_comb begin
    run_d     = run_q;
    oneshot_d = oneshot_q;
    fine_d    = fine_q;
    div_d     = div_q;
    reload_d  = reload_q;
    ien_d     = ien_q;
    flag_d    = flag_q;
    if (wr_ctrl) begin
      run_d     = wdata[B_RUN];
      oneshot_d = wdata[B_ONESHOT];
      fine_d    = wdata[B_FINE_LO +: FINE_W];
    end else if (uf_evt && oneshot_q) begin
      run_d = 1'b0;
    end
    if (wr_div)    div_d    = wdata[DIV_W-1:0];
    if (wr_reload) reload_d = wdata[CNT_W-1:0];
    if (wr_irq)    ien_d    = wdata[B_IEN];
    if (uf_evt)                         flag_d = 1'b1;
    else if (wr_irq && wdata[B_FLAG])   flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      oneshot_q <= 1'b0;
      fine_q    <= '0;
      div_q     <= '0;
      reload_q  <= '0;
      cnt_q     <= '1;
      delay_q   <= 1'b0;
      flag_q    <= 1'b0;
      ien_q     <= 1'b0;
      uf_q      <= 1'b0;
    end else begin
      run_q     <= run_d;
      oneshot_q <= oneshot_d;
      fine_q    <= fine_d;
      div_q     <= div_d;
      reload_q  <= reload_d;
      cnt_q     <= cnt_d;
      delay_q   <= delay_d;
      flag_q    <= flag_d;
      ien_q     <= ien_d;
      uf_q      <= uf_evt;
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    if (rd) begin
      case (addr)
        A_CTRL: begin
          rdata[B_RUN]                 = run_q;
          rdata[B_ONESHOT]             = oneshot_q;
          rdata[B_FINE_LO +: FINE_W]   = fine_q;
        end
        A_DIV:    rdata[DIV_W-1:0] = div_q;
        A_RELOAD: rdata[CNT_W-1:0] = reload_q;
        A_COUNT:  rdata[CNT_W-1:0] = cnt_q;
        A_IRQ: begin
          rdata[B_FLAG] = flag_q;
          rdata[B_IEN]  = ien_q;
        end
        default:  rdata = '0;
      endcase
    end
  end

  assign irq_o = flag_q && ien_q;
  assign uf_o  = uf_q;
endmodule

// File: rtl/ft_checker.sv
module ft_checker #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             uf_o,
  input logic             flag,
  input logic             run,
  input logic             oneshot,
  input logic             wr_ctrl,
  input logic             load_req,
  input logic             tick,
  input logic [DIV_W-1:0] div,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] reload
);
  logic past_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_valid <= 1'b0;
    else        past_valid <= 1'b1;
  end

  p_flag_on_uf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uf_o |-> flag);

  p_reserved_div_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (div == '1) |-> !tick);

  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && !$past(load_req) && !uf_o) |->
      (cnt == $past(cnt) || cnt == $past(cnt) - 1'b1));

  p_hold_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && !$past(run) && !$past(load_req)) |-> $stable(cnt));

  p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && uf_o && $past(oneshot) && !$past(wr_ctrl)) |-> !run);

  p_load_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_valid && $past(load_req)) |-> (cnt == $past(reload)));
endmodule

bind fine_reload_timer ft_checker #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .uf_o(uf_o), .flag(flag_q), .run(run_q),
  .oneshot(oneshot_q), .wr_ctrl(wr_ctrl), .load_req(load_req), .tick(tick),
  .div(div_q), .cnt(cnt_q), .reload(reload_q)
);

// File: tb/fine_reload_timer_tb.sv
module fine_reload_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] addr = 3'd3;
  logic [15:0] wdata = '0;
  logic wr = 1'b0, rd = 1'b1;
  logic [15:0] rdata;
  logic irq_o, uf_o;

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit done = 0;

  // behavioural reference model state
  int m_run, m_one, m_fine, m_div, m_reload, m_cnt, m_del, m_flag, m_ien, m_pre, m_idx, m_uf;

  fine_reload_timer u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr(wr), .rd(rd), .rdata(rdata), .irq_o(irq_o), .uf_o(uf_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic int bitrev4(input int v);
    int r = 0;
    for (int i = 0; i < 4; i++) if ((v >> i) & 1) r |= 1 << (3 - i);
    return r;
  endfunction

  function automatic int exp_read(input int a);
    case (a)
      0: return m_run | (m_one << 2) | (m_fine << 4);
      1: return m_div;
      2: return m_reload;
      3: return m_cnt;
      4: return m_flag | (m_ien << 1);
      default: return 0;
    endcase
  endfunction

  task automatic model_reset();
    m_run = 0; m_one = 0; m_fine = 0; m_div = 0; m_reload = 0; m_cnt = 255;
    m_del = 0; m_flag = 0; m_ien = 0; m_pre = 0; m_idx = 0; m_uf = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int tick, n_pre, uf, n_run;
      cyc++;
      tick = m_run && m_div != 15 && (((m_pre + 1) % (1 << m_div)) == 0);
      n_pre = m_run ? (m_pre + 1) % 16384 : 0;
      uf = 0;
      if (wr && addr == 0 && wdata[1]) begin m_cnt = m_reload; m_del = 0; end
      else if (tick) begin
        if (m_cnt != 0) m_cnt--;
        else if (bitrev4(m_idx) < m_fine && !m_del) m_del = 1;
        else begin uf = 1; m_cnt = m_reload; m_del = 0; m_idx = (m_idx + 1) % 16; end
      end
      n_run = m_run;
      if (wr && addr == 0) n_run = wdata[0];
      else if (uf && m_one) n_run = 0;
      if (wr && addr == 0) begin m_one = wdata[2]; m_fine = wdata[7:4]; end
      if (wr && addr == 1) m_div = wdata[3:0];
      if (wr && addr == 2) m_reload = wdata[7:0];
      if (uf) m_flag = 1;
      else if (wr && addr == 4 && wdata[0]) m_flag = 0;
      if (wr && addr == 4) m_ien = wdata[1];
      m_run = n_run; m_pre = n_pre; m_uf = uf;
    end
  end

  // cycle-by-cycle comparison, after the edge has settled
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk(uf_o == m_uf, "R4 uf_o", uf_o, m_uf);
      chk(irq_o == (m_flag && m_ien), "R9 irq_o", irq_o, m_flag && m_ien);
      if (rd) chk(rdata == exp_read(addr), (addr == 3) ? "R4 counter" : "R2 readback",
                  rdata, exp_read(addr));
    end
  end

  task automatic bus_write(input int a, input int d);
    @(negedge clk); addr = a[2:0]; wdata = d[15:0]; wr = 1; rd = 0;
    @(negedge clk); wr = 0; rd = 1; addr = 3'd3;
  endtask

  task automatic bus_read(input int a, output int d);
    @(negedge clk); addr = a[2:0]; rd = 1; #1 d = rdata;
  endtask

  task automatic idle(input int n);
    @(negedge clk); addr = 3'd3; rd = 1;
    repeat (n) @(negedge clk);
  endtask

  task automatic next_uf(output int t);
    @(negedge clk);
    while (!uf_o) @(negedge clk);
    t = cyc;
  endtask

  task automatic span16(input int fine, output int span);
    int t0, t1;
    bus_write(0, 1 | (fine << 4));
    next_uf(t0);
    t1 = t0;
    for (int k = 0; k < 16; k++) next_uf(t1);
    span = t1 - t0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int d, t0, t1, span, cnt_uf;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    bus_read(0, d); chk(d == 0, "R1 ctrl reset", d, 0);
    bus_read(1, d); chk(d == 0, "R1 div reset", d, 0);
    bus_read(2, d); chk(d == 0, "R1 reload reset", d, 0);
    bus_read(3, d); chk(d == 16'h00FF, "R1 counter reset", d, 16'h00FF);
    bus_read(4, d); chk(d == 0, "R1 irq reset", d, 0);
    chk(!irq_o && !uf_o, "R1 outputs low", {irq_o, uf_o}, 0);

    // R2 reserved bits, read-only counter, unused address
    bus_write(1, 16'hFFF3); bus_read(1, d); chk(d == 16'h0003, "R2 div mask", d, 3);
    bus_write(2, 16'hAB12); bus_read(2, d); chk(d == 16'h0012, "R2 reload mask", d, 16'h12);
    bus_write(3, 16'h0042); bus_read(3, d); chk(d == 16'h00FF, "R2 counter read-only", d, 16'hFF);
    bus_write(5, 16'hFFFF); bus_read(5, d); chk(d == 0, "R2 unused addr", d, 0);
    bus_write(0, 16'hFF08); bus_read(0, d); chk(d == 0, "R2 ctrl reserved", d, 0);

    // R4 repeat period, code 0, reload 3
    bus_write(4, 2);
    bus_write(1, 0); bus_write(2, 3);
    bus_write(0, 1);
    next_uf(t0); next_uf(t1); chk(t1 - t0 == 4, "R4 period reload 3", t1 - t0, 4);
    // R3 code 2 gives 16 clocks per period
    bus_write(1, 2);
    next_uf(t0); next_uf(t1); chk(t1 - t0 == 16, "R3 period code 2", t1 - t0, 16);
    chk(irq_o == 1, "R9 irq with enable", irq_o, 1);

    // R7 stop freezes counter
    bus_write(0, 0);
    bus_read(3, d); idle(12); bus_read(3, t0);
    chk(d == t0, "R7 stopped hold", t0, d);
    bus_read(0, d); chk(d == 0, "R7 run readback", d, 0);

    // R8 load-now, and load bit written 0
    bus_write(2, 16'h55); bus_write(0, 2);
    bus_read(3, d); chk(d == 16'h55, "R8 load now", d, 16'h55);
    bus_write(2, 16'h10); bus_write(0, 0);
    bus_read(3, d); chk(d == 16'h55, "R8 load bit 0 no effect", d, 16'h55);
    bus_read(0, d); chk(d == 0, "R8 load bit reads 0", d, 0);

    // R9 flag clear and write-0
    bus_write(4, 16'h0002); bus_read(4, d); chk(d == 3, "R9 write 0 keeps flag", d, 3);
    bus_write(4, 16'h0003); bus_read(4, d); chk(d == 2, "R9 write 1 clears flag", d, 2);
    chk(irq_o == 0, "R9 irq low after clear", irq_o, 0);

    // R6 one-shot: exactly one underflow, run clears
    bus_write(1, 0); bus_write(2, 2); bus_write(0, 2);
    bus_write(0, 16'h0005);
    cnt_uf = 0;
    for (int k = 0; k < 20; k++) begin @(negedge clk); if (uf_o) cnt_uf++; end
    chk(cnt_uf == 1, "R6 one-shot single underflow", cnt_uf, 1);
    bus_read(0, d); chk(d == 16'h0004, "R6 run cleared", d, 4);
    // R6 repeat keeps run
    bus_write(0, 1); idle(10);
    bus_read(0, d); chk(d == 1, "R6 repeat keeps run", d, 1);

    // R5 fine cycle spans
    bus_write(2, 0);
    span16(0, span);  chk(span == 16, "R5 fine 0 span", span, 16);
    span16(5, span);  chk(span == 21, "R5 fine 5 span", span, 21);
    span16(15, span); chk(span == 31, "R5 fine 15 span", span, 31);

    // R3 reserved code 15 never counts
    bus_write(0, 0); bus_write(2, 16'h20); bus_write(0, 2);
    bus_write(1, 15); bus_write(0, 1);
    idle(40); bus_read(3, d); chk(d == 16'h20, "R3 code 15 no count", d, 16'h20);
    bus_write(0, 0);

    idle(4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule